// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries a 32-bit processor from the moment an exception is raised to the point where the handler's first instruction address is known. A request carries an 8-bit vector number. The number comes either from an interrupt acknowledge cycle (`req_is_irq` high, with the acknowledged level on `req_level`) or from an internal source such as a trap (`req_is_irq` low).

The sequencer works through a fixed series of steps. First it copies the status word and derives the supervisor status from it. It then locates the vector slot within a relocatable table whose base comes from `vbr`. Next it pushes a three-item frame onto the supervisor stack through a request/ready memory port. Finally it reads the handler address from the table.

The pushed frame contains the status and program counter as they stood before the exception. It also contains a tag word that holds a format code and the vector's byte offset, so that one common handler can decode any frame. Once the handler address has arrived, the sequencer reports it with a single-cycle `done` pulse, together with the updated status and stack pointer.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset `busy`, `done` and `mem_req` are low.
- R2: From the cycle after a request is accepted, `new_sr` equals the captured status word with bit 13 (supervisor) set and bits 15:14 (trace) cleared. When `req_is_irq` is high, bits 10:8 are replaced by `req_level`. All other bits are kept.
- R3: `new_ssp` equals `ssp_in` minus 8, modulo 2^32.
- R4: The first memory access is a word write (`mem_size`=0, `mem_we`=1) to `new_ssp`+6. Its data bits 15:12 hold the format code `FRAME_FMT`, bits 11:0 hold vector×4, and bits 31:16 are zero.
- R5: The second access is a long-word write (`mem_size`=1) to `new_ssp`+2 carrying the captured PC.
- R6: The third access is a word write to `new_ssp` carrying the pre-exception status word in bits 15:0, with bits 31:16 zero.
- R7: The fourth access is a long-word read (`mem_we`=0) from `vbr` + vector×4.
- R8: While `mem_req` is high and `mem_ready` is low, the request, address, direction, size and write data hold unchanged.
- R9: `done` pulses for exactly one cycle, in the cycle after the read is accepted. `new_pc` then equals the data that was read.
- R10: A request raised while `busy` is high is ignored: it does not change the access sequence, and it produces no further access and no further `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Exception request |
| req_vector | input | 8 | Vector number |
| req_is_irq | input | 1 | Request comes from an interrupt acknowledge |
| req_level | input | 3 | Acknowledged interrupt level |
| cur_sr | input | 16 | Status word before the exception |
| cur_pc | input | 32 | Program counter to save |
| vbr | input | 32 | Vector table base |
| ssp_in | input | 32 | Supervisor stack pointer before the push |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 1 | 1 = long word, 0 = word |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data (word data in bits 15:0) |
| mem_ready | input | 1 | Access accepted on this edge |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | 32 | Handler address |
| new_sr | output | 16 | Status word for the handler |
| new_ssp | output | 32 | Supervisor stack pointer after the push |

## Verification
A request sampled on one edge makes `busy`, `new_sr` and `new_ssp` valid right after that edge, and `mem_req` rises at the same time. Each memory access completes on the edge where `mem_ready` is high. `done` and `new_pc` appear right after the edge that takes the read data and stay for one cycle. The bench drives inputs and samples outputs on the falling edge. A memory model answers each access after a stall count taken from the vector table, and it logs every accepted access. The bench waits for `done`, checks the logged accesses in order, and checks one falling edge later that `done` has dropped.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int VEC_W = 8;
    localparam int SR_W  = 16;
    localparam int SR_T1 = 15;
    localparam int SR_T0 = 14;
    localparam int SR_S  = 13;
    localparam int SR_MASK_LO = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TAG,
        ST_PC,
        ST_SR,
        ST_VEC
    } exc_state_e;
endpackage

// File: rtl/exc_sr_mod.sv
module exc_sr_mod
    import exc_pkg::*;
(
    input  logic [SR_W-1:0] sr_in,
    input  logic            is_irq,
    input  logic [2:0]      level,
    output logic [SR_W-1:0] sr_out
);
    always_comb begin
        sr_out        = sr_in;
        sr_out[SR_T1] = 1'b0;
        sr_out[SR_T0] = 1'b0;
        sr_out[SR_S]  = 1'b1;
        if (is_irq) begin
            sr_out[SR_MASK_LO +: 3] = level;
        end
    end
endmodule

// File: rtl/exc_vec_addr.sv
module exc_vec_addr
    import exc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]    base,
    input  logic [VEC_W-1:0] vec,
    output logic [AW-1:0]    slot_addr,
    output logic [11:0]      offset
);
    localparam int OFF_W = VEC_W + 2;

    logic [OFF_W-1:0] byte_off;

    always_comb begin
        byte_off  = {vec, 2'b00};
        slot_addr = base + {{(AW-OFF_W){1'b0}}, byte_off};
        offset    = {{(12-OFF_W){1'b0}}, byte_off};
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter logic [3:0] FRAME_FMT = 4'h0,
    parameter int         AW        = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [7:0]       req_vector,
    input  logic             req_is_irq,
    input  logic [2:0]       req_level,
    input  logic [15:0]      cur_sr,
    input  logic [AW-1:0]    cur_pc,
    input  logic [AW-1:0]    vbr,
    input  logic [AW-1:0]    ssp_in,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_size,
    output logic [AW-1:0]    mem_addr,
    output logic [AW-1:0]    mem_wdata,
    input  logic             mem_ready,
    input  logic [AW-1:0]    mem_rdata,
    output logic             busy,
    output logic             done,
    output logic [AW-1:0]    new_pc,
    output logic [15:0]      new_sr,
    output logic [AW-1:0]    new_ssp
);
    localparam int          FRAME_BYTES = 8;
    localparam logic [AW-1:0] OFS_TAG = AW'(6);
    localparam logic [AW-1:0] OFS_PC  = AW'(2);

    typedef struct packed {
        exc_state_e      st;
        logic [SR_W-1:0] sr_old;
        logic [SR_W-1:0] sr_new;
        logic [AW-1:0]   pc;
        logic [AW-1:0]   ssp;
        logic [AW-1:0]   vaddr;
        logic [11:0]     offs;
        logic [AW-1:0]   hpc;
        logic            done;
    } seq_t;

    seq_t s_q, s_d;

    logic [SR_W-1:0] sr_mod_w;
    logic [AW-1:0]   vaddr_w;
    logic [11:0]     offs_w;

    exc_sr_mod i_sr_mod (
        .sr_in  (cur_sr),
        .is_irq (req_is_irq),
        .level  (req_level),
        .sr_out (sr_mod_w)
    );

    exc_vec_addr #(.AW(AW)) i_vec_addr (
        .base      (vbr),
        .vec       (req_vector),
        .slot_addr (vaddr_w),
        .offset    (offs_w)
    );

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_size  = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.st     = ST_TAG;
                    s_d.sr_old = cur_sr;
                    s_d.sr_new = sr_mod_w;
                    s_d.pc     = cur_pc;
                    s_d.ssp    = ssp_in - AW'(FRAME_BYTES);
                    s_d.vaddr  = vaddr_w;
                    s_d.offs   = offs_w;
                end
            end
            ST_TAG: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = s_q.ssp + OFS_TAG;
                mem_wdata = {{(AW-16){1'b0}}, FRAME_FMT, s_q.offs};
                if (mem_ready) s_d.st = ST_PC;
            end
            ST_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_size  = 1'b1;
                mem_addr  = s_q.ssp + OFS_PC;
                mem_wdata = s_q.pc;
                if (mem_ready) s_d.st = ST_SR;
            end
            ST_SR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = s_q.ssp;
                mem_wdata = {{(AW-SR_W){1'b0}}, s_q.sr_old};
                if (mem_ready) s_d.st = ST_VEC;
            end
            ST_VEC: begin
                mem_req  = 1'b1;
                mem_size = 1'b1;
                mem_addr = s_q.vaddr;
                if (mem_ready) begin
                    s_d.st   = ST_IDLE;
                    s_d.hpc  = mem_rdata;
                    s_d.done = 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = (s_q.st != ST_IDLE);
    assign done    = s_q.done;
    assign new_pc  = s_q.hpc;
    assign new_sr  = s_q.sr_new;
    assign new_ssp = s_q.ssp;

    // R1: no memory traffic while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R2: handler status is supervisor with trace off while running
    a_r2_super: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (new_sr[SR_S] && new_sr[SR_T1:SR_T0] == 2'b00));

    // R8: a stalled access holds every attribute
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
            $stable(mem_we) && $stable(mem_size) && $stable(mem_wdata)));

    // R9: completion is a single-cycle pulse with the sequencer idle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;
    localparam logic [3:0]  FMT    = 4'h6;
    localparam logic [31:0] RD_KEY = 32'h5A5A_0001;

    typedef struct packed {
        logic [7:0]  vec;
        logic        irq;
        logic [2:0]  lvl;
        logic [15:0] sr;
        logic [31:0] pc;
        logic [31:0] vbr;
        logic [31:0] ssp;
        logic [1:0]  stall;
    } row_t;

    localparam int NROWS = 4;
    localparam row_t TBL [NROWS] = '{
        '{8'h19, 1'b1, 3'd5, 16'h8015, 32'h0000_1234, 32'h0000_0000, 32'h0000_2000, 2'd0},
        '{8'h04, 1'b0, 3'd3, 16'h4305, 32'h0040_0ABC, 32'h0010_0000, 32'h0000_8000, 2'd2},
        '{8'hFF, 1'b1, 3'd7, 16'h0000, 32'hFFFF_FFFE, 32'hFFFF_FC00, 32'h0000_0008, 2'd1},
        '{8'h00, 1'b0, 3'd0, 16'hC71F, 32'h0000_0000, 32'h1234_5678, 32'h0000_0004, 2'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_vector = '0;
    logic        req_is_irq = 1'b0;
    logic [2:0]  req_level = '0;
    logic [15:0] cur_sr = '0;
    logic [31:0] cur_pc = '0;
    logic [31:0] vbr = '0;
    logic [31:0] ssp_in = '0;
    logic        mem_req, mem_we, mem_size;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        busy, done;
    logic [31:0] new_pc, new_ssp;
    logic [15:0] new_sr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int stall_cfg = 0;
    int wcnt = 0;
    int nlog = 0;
    logic [31:0] log_addr [64];
    logic [31:0] log_data [64];
    logic        log_we   [64];
    logic        log_size [64];

    always #2 clk = ~clk;

    exc_entry_seq #(.FRAME_FMT(FMT)) i_exc_entry_seq (
        .clk, .rst_n, .req_valid, .req_vector, .req_is_irq, .req_level,
        .cur_sr, .cur_pc, .vbr, .ssp_in,
        .mem_req, .mem_we, .mem_size, .mem_addr, .mem_wdata,
        .mem_ready, .mem_rdata,
        .busy, .done, .new_pc, .new_sr, .new_ssp
    );

    // memory model: answers after stall_cfg idle cycles, logs accepted accesses
    always @(negedge clk) begin
        if (mem_ready) begin
            mem_ready = 1'b0;
            wcnt = 0;
        end else if (mem_req) begin
            if (wcnt >= stall_cfg) begin
                mem_ready = 1'b1;
                mem_rdata = mem_addr ^ RD_KEY;
                if (nlog < 64) begin
                    log_addr[nlog] = mem_addr;
                    log_data[nlog] = mem_we ? mem_wdata : 32'h0;
                    log_we[nlog]   = mem_we;
                    log_size[nlog] = mem_size;
                end
                nlog = nlog + 1;
            end else begin
                wcnt = wcnt + 1;
            end
        end else begin
            wcnt = 0;
        end
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_acc(input int idx, input string req, input logic we, input logic sz,
                           input logic [31:0] addr, input logic [31:0] data);
        logic [65:0] a, e;
        a = {log_we[idx], log_size[idx], log_addr[idx], log_data[idx]};
        e = {we, sz, addr, data};
        checks = checks + 1;
        if (idx >= nlog || a != e) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", req, a, e);
        end
    endtask

    task automatic issue(input row_t r);
        @(negedge clk);
        stall_cfg  = int'(r.stall);
        req_vector = r.vec;
        req_is_irq = r.irq;
        req_level  = r.lvl;
        cur_sr     = r.sr;
        cur_pc     = r.pc;
        vbr        = r.vbr;
        ssp_in     = r.ssp;
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (done) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    function automatic logic [15:0] exp_sr(input row_t r);
        logic [15:0] s;
        s = r.sr;
        s[15:14] = 2'b00;
        s[13] = 1'b1;
        if (r.irq) s[10:8] = r.lvl;
        return s;
    endfunction

    task automatic check_row(input row_t r, input int base, input string tag);
        logic [31:0] sp, va;
        bit seen;
        sp = r.ssp - 32'd8;
        va = r.vbr + {22'd0, r.vec, 2'b00};
        // one cycle after acceptance the status and stack pointer are valid
        chk(busy == 1'b1, {tag, " R2 busy"}, 64'(busy), 64'd1);
        chk(new_sr == exp_sr(r), {tag, " R2 new_sr"}, 64'(new_sr), 64'(exp_sr(r)));
        chk(new_ssp == sp, {tag, " R3 new_ssp"}, 64'(new_ssp), 64'(sp));
        wait_done(seen);
        chk(seen, {tag, " R9 done seen"}, 64'(seen), 64'd1);
        chk(new_pc == (va ^ RD_KEY), {tag, " R9 new_pc"}, 64'(new_pc), 64'(va ^ RD_KEY));
        chk(nlog - base == 4, {tag, " R7 access count"}, 64'(nlog - base), 64'd4);
        chk_acc(base + 0, {tag, " R4 tag word"}, 1'b1, 1'b0, sp + 32'd6,
                {16'h0, FMT, 2'b00, r.vec, 2'b00});
        chk_acc(base + 1, {tag, " R5 pc long"}, 1'b1, 1'b1, sp + 32'd2, r.pc);
        chk_acc(base + 2, {tag, " R6 sr word"}, 1'b1, 1'b0, sp, {16'h0, r.sr});
        chk_acc(base + 3, {tag, " R7 vector read"}, 1'b0, 1'b1, va, 32'h0);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R9 done one cycle"}, 64'(done), 64'd0);
    endtask

    initial begin
        row_t alt;
        int base;
        bit seen;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy", 64'(busy), 64'd0);
        chk(done == 1'b0, "R1 done", 64'(done), 64'd0);
        chk(mem_req == 1'b0, "R1 mem_req", 64'(mem_req), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_req == 1'b0, "R1 idle after reset", 64'(mem_req), 64'd0);

        for (int k = 0; k < NROWS; k++) begin
            base = nlog;
            issue(TBL[k]);
            check_row(TBL[k], base, $sformatf("row%0d", k));
            repeat (2) @(negedge clk);
        end

        // R10: second request while busy is ignored
        alt = TBL[0];
        alt.vec = 8'h3C;
        alt.vbr = 32'h0000_4000;
        base = nlog;
        issue(TBL[1]);
        @(negedge clk);
        req_vector = alt.vec;
        vbr = alt.vbr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        vbr = TBL[1].vbr;
        wait_done(seen);
        chk(seen, "R10 first run completes", 64'(seen), 64'd1);
        chk_acc(base + 3, "R10 read uses first vector", 1'b0, 1'b1,
                TBL[1].vbr + 32'h10, 32'h0);
        repeat (30) @(negedge clk);
        chk(nlog - base == 4, "R10 no extra accesses", 64'(nlog - base), 64'd4);
        chk(busy == 1'b0, "R10 idle afterwards", 64'(busy), 64'd0);

        // R1: reset in the middle of a sequence returns to idle
        issue(TBL[3]);
        rst_n = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && mem_req == 1'b0, "R1 reset mid-run",
            64'({busy, mem_req}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule